// File: doc/BRIEF.md
# Write-Status Bit Generator

This block supplies the status word that a flash-style memory returns on reads while an internal program or erase is running or paused. A command decoder outside the block drives the current operation state and latches the word being programmed and the address of the erase that was paused. The block answers each read. When `stat_en` is high, the read path replaces array bits 7, 6 and 2 with `stat_d7`, `stat_d6` and `stat_d2`. When `stat_en` is low, the read path returns array data unchanged.

Bit 7 is a polling bit. While a program runs it reads as the inverse of the target data. While an erase runs it reads as zero. Bit 6 and bit 2 are toggle bits. Each one is a register that flips once for every completed read, as marked by `rd_strobe`. Software can therefore tell a busy device apart from a finished one by reading twice and comparing. While an erase is suspended, bit 2 also shows whether the location being read lies inside the paused sector or block.

Top module: `wstat_gen`

## Requirements
- R1: `op_state` uses these codes: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend. Codes 5 to 7 behave as idle. `stat_en` is 1 in codes 1, 2 and 4. In code 3 it is 1 only for a read inside the suspended region. In every other case it is 0.
- R2: In codes 1 and 4, `stat_d7` equals the inverse of `prog_d7`.
- R3: In code 2, `stat_d7` is 0.
- R4: In codes 1, 2 and 4, `stat_d6` inverts after each cycle with `rd_strobe` high. It holds its value in cycles without a strobe.
- R5: In code 2, `stat_d2` inverts after each strobed read. In codes 1 and 4, `stat_d2` is 0.
- R6: In code 3, a read inside the suspended region gives `stat_d7`=1, `stat_d6`=1 and a `stat_d2` that inverts after each strobed hit. Strobed reads outside the region leave that toggle unchanged.
- R7: A read is inside the suspended region when `rd_addr[AW-1:SECT_LSB]` equals `susp_addr[AW-1:SECT_LSB]` and `susp_blk`=0. When `susp_blk`=1, the comparison uses bits `[AW-1:BLK_LSB]` instead.
- R8: When `op_state` changes into code 1, 2 or 4 from any other code, both toggles are cleared to 0 at the next clock edge. A strobe in that same cycle is ignored. A change into code 3 keeps the toggles.
- R9: After synchronous reset, both toggles are 0. With code 0 applied, `stat_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | Operation state code (see R1) |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| susp_addr | input | AW | Latched address of the suspended erase |
| susp_blk | input | 1 | 1 when the suspended erase covers a block, 0 for a sector |
| rd_addr | input | AW | Address of the current read |
| rd_strobe | input | 1 | One-cycle pulse marking a completed read |
| stat_en | output | 1 | Status replaces array bits 7, 6 and 2 |
| stat_d7 | output | 1 | Polling bit |
| stat_d6 | output | 1 | Operation toggle bit |
| stat_d2 | output | 1 | Erase toggle bit |

## Verification
The suspended region is swept over every read address, once in sector mode and once in block mode, against two different suspend addresses. This separates the two comparison widths and catches any off-by-one in the field bounds. Runs of strobed reads in program, erase and program-during-suspend check that each toggle advances once per read, holds without a strobe, and that bit 2 stays quiet during programming. Mixed hit and miss reads while suspended show that misses do not move bit 2. A strobe in the cycle a new operation starts shows that clearing takes priority. The idle and unused state codes, together with both values of the programmed bit, cover the enable decode and the polarity of the polling bit.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_e;

    typedef struct packed {
        logic en;
        logic b7;
        logic b6;
        logic b2;
    } stat_t;

    // states in which bit 6 advances on reads
    function automatic logic busy_op(input op_e s);
        return (s == OP_PROG) || (s == OP_ERASE) || (s == OP_SUSP_PROG);
    endfunction

endpackage

// File: rtl/wstat_region.sv
module wstat_region #(
    parameter int AW       = 8,
    parameter int SECT_LSB = 3,
    parameter int BLK_LSB  = 5
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] susp_addr,
    input  logic          susp_blk,
    output logic          hit
);
    localparam int SECT_W = AW - SECT_LSB;
    localparam int BLK_W  = AW - BLK_LSB;

    logic [SECT_W-1:0] rd_sect, su_sect;
    logic [BLK_W-1:0]  rd_blk,  su_blk;

    assign rd_sect = rd_addr[AW-1:SECT_LSB];
    assign su_sect = susp_addr[AW-1:SECT_LSB];
    assign rd_blk  = rd_addr[AW-1:BLK_LSB];
    assign su_blk  = susp_addr[AW-1:BLK_LSB];

    always_comb begin
        if (susp_blk) hit = (rd_blk == su_blk);
        else          hit = (rd_sect == su_sect);
    end

    // R7: a sector hit always lies inside the enclosing block
    always_comb begin
        if (!susp_blk && hit)
            p_sect_in_blk_r7: assert (rd_blk == su_blk);
    end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= 1'b0;
        else if (flip)  q <= ~q;
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !flip) |=> $stable(q));
endmodule

// File: rtl/wstat_decode.sv
module wstat_decode
    import wstat_pkg::*;
(
    input  op_e   st,
    input  logic  hit,
    input  logic  prog_d7,
    input  logic  strobe,
    input  logic  entry,
    input  logic  t6,
    input  logic  t2,
    output stat_t stat,
    output logic  flip6,
    output logic  flip2
);
    always_comb begin
        stat  = '0;
        flip6 = 1'b0;
        flip2 = 1'b0;
        case (st)
            OP_PROG, OP_SUSP_PROG: begin
                stat  = '{en: 1'b1, b7: ~prog_d7, b6: t6, b2: 1'b0};
                flip6 = strobe && !entry;
            end
            OP_ERASE: begin
                stat  = '{en: 1'b1, b7: 1'b0, b6: t6, b2: t2};
                flip6 = strobe && !entry;
                flip2 = strobe && !entry;
            end
            OP_SUSP: begin
                if (hit) begin
                    stat  = '{en: 1'b1, b7: 1'b1, b6: 1'b1, b2: t2};
                    flip2 = strobe;
                end
            end
            default: stat = '0;
        endcase
    end

    // R1: the idle code never overrides array data
    always_comb begin
        if (st == OP_IDLE)
            p_idle_quiet_r1: assert (!stat.en && !flip6 && !flip2);
    end
endmodule

// File: rtl/wstat_gen.sv
module wstat_gen
    import wstat_pkg::*;
#(
    parameter int AW       = 8,
    parameter int SECT_LSB = 3,
    parameter int BLK_LSB  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_state,
    input  logic          prog_d7,
    input  logic [AW-1:0] susp_addr,
    input  logic          susp_blk,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_strobe,
    output logic          stat_en,
    output logic          stat_d7,
    output logic          stat_d6,
    output logic          stat_d2
);
    op_e   st, prev_st;
    logic  entry, hit, flip6, flip2, t6, t2;
    stat_t stat;

    assign st = op_e'(op_state);

    always_ff @(posedge clk) begin
        if (rst) prev_st <= OP_IDLE;
        else     prev_st <= st;
    end

    assign entry = (st != prev_st) && busy_op(st);

    wstat_region #(.AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)) u_region (
        .rd_addr(rd_addr), .susp_addr(susp_addr), .susp_blk(susp_blk), .hit(hit)
    );

    wstat_decode u_decode (
        .st(st), .hit(hit), .prog_d7(prog_d7), .strobe(rd_strobe), .entry(entry),
        .t6(t6), .t2(t2), .stat(stat), .flip6(flip6), .flip2(flip2)
    );

    wstat_toggle u_tog6 (.clk(clk), .rst(rst), .clr(entry), .flip(flip6), .q(t6));
    wstat_toggle u_tog2 (.clk(clk), .rst(rst), .clr(entry), .flip(flip2), .q(t2));

    assign stat_en = stat.en;
    assign stat_d7 = stat.b7;
    assign stat_d6 = stat.b6;
    assign stat_d2 = stat.b2;

    p_prog_poll_r2: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd1 || op_state == 3'd4) |-> (stat_en && stat_d7 == !prog_d7));
    p_erase_poll_r3: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd2) |-> (stat_en && !stat_d7));
    p_d6_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && (op_state == 3'd1 || op_state == 3'd2 || op_state == 3'd4)
         && op_state == prev_st)
        |=> (op_state != $past(op_state)) || (stat_d6 != $past(stat_d6)));
    p_susp_hit_r6: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd3 && stat_en) |-> (stat_d7 && stat_d6));
    p_prog_no_d2_r5: assert property (@(posedge clk) disable iff (rst)
        (op_state == 3'd1 || op_state == 3'd4) |-> !stat_d2);
endmodule

// File: tb/wstat_gen_test.sv
module wstat_gen_test;
    localparam int AW = 8, SL = 3, BL = 5;

    logic          clk = 0, rst = 1;
    logic [2:0]    op_state = 0;
    logic          prog_d7 = 0, susp_blk = 0, rd_strobe = 0;
    logic [AW-1:0] susp_addr = 0, rd_addr = 0;
    logic          stat_en, stat_d7, stat_d6, stat_d2;

    int total = 0, bad = 0;
    bit mt6 = 0, mt2 = 0;
    int cur = 0, prev = 0;

    wstat_gen #(.AW(AW), .SECT_LSB(SL), .BLK_LSB(BL)) uut (
        .clk(clk), .rst(rst), .op_state(op_state), .prog_d7(prog_d7),
        .susp_addr(susp_addr), .susp_blk(susp_blk), .rd_addr(rd_addr),
        .rd_strobe(rd_strobe), .stat_en(stat_en), .stat_d7(stat_d7),
        .stat_d6(stat_d6), .stat_d2(stat_d2)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_hit(input int a);
        if (susp_blk) return (a >> BL) == (int'(susp_addr) >> BL);
        return (a >> SL) == (int'(susp_addr) >> SL);
    endfunction

    function automatic bit busy(input int s);
        return s == 1 || s == 2 || s == 4;
    endfunction

    // one read: check outputs, optionally strobe, update model
    task automatic rd(input int a, input bit strobe, input string tag);
        bit h;
        @(negedge clk);
        rd_addr = a[AW-1:0];
        rd_strobe = strobe;
        #1;
        h = is_hit(a);
        case (cur)
            1, 4: begin
                chk({tag, " R1 en"}, stat_en, 1);
                chk({tag, " R2 d7"}, stat_d7, !prog_d7);
                chk({tag, " R4 d6"}, stat_d6, mt6);
                chk({tag, " R5 d2"}, stat_d2, 0);
            end
            2: begin
                chk({tag, " R1 en"}, stat_en, 1);
                chk({tag, " R3 d7"}, stat_d7, 0);
                chk({tag, " R4 d6"}, stat_d6, mt6);
                chk({tag, " R5 d2"}, stat_d2, mt2);
            end
            3: begin
                chk({tag, " R7 en"}, stat_en, h);
                if (h) begin
                    chk({tag, " R6 d7"}, stat_d7, 1);
                    chk({tag, " R6 d6"}, stat_d6, 1);
                    chk({tag, " R6 d2"}, stat_d2, mt2);
                end
            end
            default: chk({tag, " R1 en"}, stat_en, 0);
        endcase
        @(negedge clk);
        rd_strobe = 0;
        if (strobe) begin
            if (busy(cur)) mt6 = !mt6;
            if (cur == 2 || (cur == 3 && h)) mt2 = !mt2;
        end
    endtask

    task automatic go(input int s, input bit strobe);
        @(negedge clk);
        op_state = s[2:0];
        rd_strobe = strobe;
        cur = s;
        @(negedge clk);
        rd_strobe = 0;
        if (s != prev && busy(s)) begin mt6 = 0; mt2 = 0; end
        else if (strobe) begin
            if (busy(s)) mt6 = !mt6;
        end
        prev = s;
    endtask

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        rd(0, 0, "R9 reset");
        for (int s = 5; s < 8; s++) begin
            go(s, 0);
            rd(17, 1, "R1 unused code");
        end
        go(0, 0);
        rd(3, 1, "R1 idle");

        // program, both data polarities
        for (int p = 0; p < 2; p++) begin
            prog_d7 = p[0];
            go(1, 0);
            for (int i = 0; i < 6; i++) rd(i * 37, (i % 3) != 2, "R4 prog");
            go(0, 0);
        end

        // erase
        go(2, 0);
        for (int i = 0; i < 7; i++) rd(i * 11, (i % 4) != 3, "R5 erase");
        // suspend keeps toggles (R8)
        susp_addr = 8'h5A;
        for (int b = 0; b < 2; b++) begin
            susp_blk = b[0];
            go(3, 0);
            for (int a = 0; a < 256; a++) rd(a, 0, "R7 sweep");
        end
        susp_addr = 8'hC3;
        susp_blk = 0;
        for (int a = 0; a < 256; a += 3) rd(a, 0, "R7 sweep2");
        // hit and miss strobes
        for (int i = 0; i < 8; i++) rd((i % 2) ? 8'hC5 : 8'h10, 1, "R6 hit/miss");
        rd(8'hC0, 0, "R6 after misses");
        susp_blk = 1;
        rd(8'hDF, 1, "R6 block hit");
        rd(8'hE0, 1, "R6 block miss");
        rd(8'hC0, 0, "R6 block check");

        // program during suspend, from suspend
        prog_d7 = 1;
        go(4, 0);
        for (int i = 0; i < 6; i++) rd(i * 45, 1, "R2 susp prog");
        go(3, 0);
        rd(8'hC1, 1, "R8 back to suspend");
        rd(8'hC1, 0, "R8 back to suspend");
        // resume erase clears
        go(2, 0);
        rd(0, 1, "R8 resume");
        rd(0, 1, "R8 resume");
        rd(0, 0, "R8 resume");
        // strobe in entry cycle ignored
        go(0, 0);
        go(1, 1);
        rd(5, 0, "R8 entry strobe");
        rd(5, 0, "R4 hold");
        go(0, 0);
        rd(5, 0, "R1 idle end");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule